// File: doc/BRIEF.md
# Serial Command EEPROM Page Programmer

This block interprets single-character commands that arrive on a byte-wide serial receive stream. It answers on a byte-wide transmit stream. Both streams use valid/ready handshakes. The three commands are a size probe, a page-aligned burst write into a two-wire serial EEPROM, and a file read. The block reaches the EEPROM through a byte-level transaction port: it issues start, write-byte and stop requests, and each request is finished by a done pulse that carries the target's acknowledge. For the file read it delegates to an external file reader. It asks that reader to open a file by a one-byte reference, then forwards the bytes the reader returns.

A host first sends a probe to learn the memory size. It then programs the memory one page at a time, and can read back stored files. Every reply is framed: a successful write or read is bracketed by an opening and a closing square bracket, and a failed write or read is answered by an exclamation mark alone. Bit timing of the two-wire bus and the line coding of the serial link belong to neighbouring blocks.

Top module: `eeprom_cmd_loader`

## Requirements
- R1: While reset is high, and in the first cycle after it, `tx_valid`, `bus_req_valid` and `file_open_req` are low. In the idle state `rx_ready` is high. Reset is synchronous and active high.
- R2: The command byte 0x3F ('?') is answered by 0x23 ('#') and then one byte equal to MEM_BYTES/256. No bus request is made.
- R3: The command byte 0x57 ('W') is followed by an address high byte and an address low byte. The block then issues, in order: START (op 0), WRITE (op 1) of DEV_WR, WRITE of the high byte, and WRITE of the low byte with its log2(PAGE_BYTES) least significant bits cleared.
- R4: If any of those three WRITE requests finishes with `bus_nack` high, the next request is STOP (op 3). The only reply is 0x21 ('!'), and the block returns to idle.
- R5: When all three address-phase writes are acknowledged, the block replies 0x5B ('['). It then accepts exactly PAGE_BYTES further bytes and issues one WRITE for each, in arrival order. A nack on a data write changes nothing.
- R6: After the last data write completes, the block issues STOP and then replies 0x5D (']').
- R7: The command byte 0x52 ('R') is followed by a reference byte. The block raises `file_open_req` with `file_ref` equal to that byte. On a successful open it replies '[', then every file byte in order, then ']' after the byte marked last.
- R8: If the open completes with `file_open_ok` low, the only reply is '!'.
- R9: Any other command byte produces no reply, no bus request and no open request, and the block stays idle.
- R10: A pending transmit byte, a pending bus request and a pending open request each hold their value until they are accepted or completed.
- R11: Received bytes are taken only by the handshake, so bytes offered while a reply is still pending are neither lost nor consumed early. `rx_ready` and `bus_req_valid` are never high together.
- R12: A synchronous reset in the middle of a command returns the block to idle, ready for a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block takes the received byte |
| tx_valid | output | 1 | Reply byte available |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Serial transmitter takes the reply byte |
| bus_req_valid | output | 1 | Bus transaction requested, held until done |
| bus_req_op | output | 2 | 0 start, 1 write byte, 2 read byte, 3 stop |
| bus_req_wdata | output | 8 | Byte to write |
| bus_done | input | 1 | Current bus request finished (one-cycle pulse) |
| bus_nack | input | 1 | Target did not acknowledge the written byte (valid with bus_done) |
| file_open_req | output | 1 | Open request to the file reader, held until done |
| file_ref | output | 8 | File reference byte |
| file_open_done | input | 1 | Open attempt finished (one-cycle pulse) |
| file_open_ok | input | 1 | Open succeeded (valid with file_open_done) |
| file_data_valid | input | 1 | File byte available |
| file_data | input | 8 | File byte |
| file_data_last | input | 1 | This file byte is the final one |
| file_data_ready | output | 1 | Block takes the file byte |

## Verification
The bench builds the block with PAGE_BYTES = 8 and MEM_BYTES = 2048. A full page burst therefore takes only eight data writes, and the probe answer is the small value 8. This makes it cheap to sweep address low bytes across the whole range, to place the nack on each address-phase write in turn, and to read files of every length from one to five bytes. Command bytes spaced evenly across the 0 to 255 range are sent to confirm that they are ignored. Three transmit back-pressure patterns are combined with the sweeps, so data bytes are offered while a reply is still stalled.

// File: rtl/eecl_pkg.sv
package eecl_pkg;

    typedef enum logic [1:0] {
        BOP_START = 2'd0,
        BOP_WRITE = 2'd1,
        BOP_READ  = 2'd2,
        BOP_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROBE,
        ST_GET_AH,
        ST_GET_AL,
        ST_GET_REF,
        ST_W_START,
        ST_W_DEV,
        ST_W_AH,
        ST_W_AL,
        ST_W_RX,
        ST_W_DATA,
        ST_W_STOP_OK,
        ST_W_STOP_ERR,
        ST_R_OPEN,
        ST_R_STREAM,
        ST_SEND
    } state_e;

    typedef struct packed {
        state_e     st;
        state_e     ret;
        logic [7:0] reply;
        logic [7:0] addr_hi;
        logic [7:0] addr_lo;
        logic [7:0] wbyte;
        logic [7:0] fref;
    } ctrl_t;

endpackage

// File: rtl/eecl_tx_slot.sv
module eecl_tx_slot (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_data,
    output logic       free,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready
);
    logic       full_d, full_q;
    logic [7:0] byte_d, byte_q;

    always_comb begin
        full_d = full_q;
        byte_d = byte_q;
        if (full_q && tx_ready) begin
            full_d = 1'b0;
        end
        if (load) begin
            full_d = 1'b1;
            byte_d = load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            byte_q <= 8'h00;
        end else begin
            full_q <= full_d;
            byte_q <= byte_d;
        end
    end

    assign free     = !full_q;
    assign tx_valid = full_q;
    assign tx_data  = byte_q;

    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R10
    load_free_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> !tx_valid);

endmodule

// File: rtl/eecl_beat_counter.sv
module eecl_beat_counter #(
    parameter int COUNT = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int CW = (COUNT > 1) ? $clog2(COUNT) : 1;
    localparam logic [CW-1:0] TOP = CW'(COUNT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign last = (cnt_q == TOP);

endmodule

// File: rtl/eeprom_cmd_loader.sv
module eeprom_cmd_loader
    import eecl_pkg::*;
#(
    parameter int         MEM_BYTES  = 32768,
    parameter int         PAGE_BYTES = 32,
    parameter logic [7:0] DEV_WR     = 8'hA0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    output logic       bus_req_valid,
    output logic [1:0] bus_req_op,
    output logic [7:0] bus_req_wdata,
    input  logic       bus_done,
    input  logic       bus_nack,
    output logic       file_open_req,
    output logic [7:0] file_ref,
    input  logic       file_open_done,
    input  logic       file_open_ok,
    input  logic       file_data_valid,
    input  logic [7:0] file_data,
    input  logic       file_data_last,
    output logic       file_data_ready
);
    localparam logic [7:0] SIZE_CODE = 8'(MEM_BYTES / 256);
    localparam logic [7:0] OFFS_MASK = 8'(PAGE_BYTES - 1);
    localparam logic [7:0] CH_PROBE  = 8'h3F;
    localparam logic [7:0] CH_WRITE  = 8'h57;
    localparam logic [7:0] CH_READ   = 8'h52;
    localparam logic [7:0] CH_SIZE   = 8'h23;
    localparam logic [7:0] CH_OPEN   = 8'h5B;
    localparam logic [7:0] CH_CLOSE  = 8'h5D;
    localparam logic [7:0] CH_ERR    = 8'h21;

    ctrl_t      c_d, c_q;
    bus_op_e    op_c;
    logic       slot_free;
    logic       slot_load;
    logic [7:0] slot_byte;
    logic       cnt_clear, cnt_step, cnt_last;

    eecl_tx_slot u_slot (
        .clk       (clk),
        .rst       (rst),
        .load      (slot_load),
        .load_data (slot_byte),
        .free      (slot_free),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready)
    );

    eecl_beat_counter #(.COUNT(PAGE_BYTES)) u_beats (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clear),
        .step  (cnt_step),
        .last  (cnt_last)
    );

    always_comb begin
        c_d             = c_q;
        rx_ready        = 1'b0;
        bus_req_valid   = 1'b0;
        op_c            = BOP_START;
        bus_req_wdata   = 8'h00;
        file_open_req   = 1'b0;
        file_data_ready = 1'b0;
        slot_load       = 1'b0;
        slot_byte       = 8'h00;
        cnt_clear       = 1'b0;
        cnt_step        = 1'b0;

        case (c_q.st)
            ST_IDLE: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    if (rx_data == CH_PROBE)      c_d.st = ST_PROBE;
                    else if (rx_data == CH_WRITE) c_d.st = ST_GET_AH;
                    else if (rx_data == CH_READ)  c_d.st = ST_GET_REF;
                end
            end
            ST_PROBE: begin
                if (slot_free) begin
                    slot_load = 1'b1;
                    slot_byte = CH_SIZE;
                    c_d.reply = SIZE_CODE;
                    c_d.ret   = ST_IDLE;
                    c_d.st    = ST_SEND;
                end
            end
            ST_GET_AH: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    c_d.addr_hi = rx_data;
                    c_d.st      = ST_GET_AL;
                end
            end
            ST_GET_AL: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    c_d.addr_lo = rx_data & ~OFFS_MASK;
                    c_d.st      = ST_W_START;
                end
            end
            ST_W_START: begin
                bus_req_valid = 1'b1;
                op_c          = BOP_START;
                if (bus_done) c_d.st = ST_W_DEV;
            end
            ST_W_DEV: begin
                bus_req_valid = 1'b1;
                op_c          = BOP_WRITE;
                bus_req_wdata = DEV_WR;
                if (bus_done) c_d.st = bus_nack ? ST_W_STOP_ERR : ST_W_AH;
            end
            ST_W_AH: begin
                bus_req_valid = 1'b1;
                op_c          = BOP_WRITE;
                bus_req_wdata = c_q.addr_hi;
                if (bus_done) c_d.st = bus_nack ? ST_W_STOP_ERR : ST_W_AL;
            end
            ST_W_AL: begin
                bus_req_valid = 1'b1;
                op_c          = BOP_WRITE;
                bus_req_wdata = c_q.addr_lo;
                if (bus_done) begin
                    if (bus_nack) begin
                        c_d.st = ST_W_STOP_ERR;
                    end else begin
                        cnt_clear = 1'b1;
                        c_d.reply = CH_OPEN;
                        c_d.ret   = ST_W_RX;
                        c_d.st    = ST_SEND;
                    end
                end
            end
            ST_W_RX: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    c_d.wbyte = rx_data;
                    c_d.st    = ST_W_DATA;
                end
            end
            ST_W_DATA: begin
                bus_req_valid = 1'b1;
                op_c          = BOP_WRITE;
                bus_req_wdata = c_q.wbyte;
                if (bus_done) begin
                    cnt_step = 1'b1;
                    c_d.st   = cnt_last ? ST_W_STOP_OK : ST_W_RX;
                end
            end
            ST_W_STOP_OK: begin
                bus_req_valid = 1'b1;
                op_c          = BOP_STOP;
                if (bus_done) begin
                    c_d.reply = CH_CLOSE;
                    c_d.ret   = ST_IDLE;
                    c_d.st    = ST_SEND;
                end
            end
            ST_W_STOP_ERR: begin
                bus_req_valid = 1'b1;
                op_c          = BOP_STOP;
                if (bus_done) begin
                    c_d.reply = CH_ERR;
                    c_d.ret   = ST_IDLE;
                    c_d.st    = ST_SEND;
                end
            end
            ST_GET_REF: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    c_d.fref = rx_data;
                    c_d.st   = ST_R_OPEN;
                end
            end
            ST_R_OPEN: begin
                file_open_req = 1'b1;
                if (file_open_done) begin
                    c_d.reply = file_open_ok ? CH_OPEN : CH_ERR;
                    c_d.ret   = file_open_ok ? ST_R_STREAM : ST_IDLE;
                    c_d.st    = ST_SEND;
                end
            end
            ST_R_STREAM: begin
                file_data_ready = slot_free;
                if (slot_free && file_data_valid) begin
                    slot_load = 1'b1;
                    slot_byte = file_data;
                    if (file_data_last) begin
                        c_d.reply = CH_CLOSE;
                        c_d.ret   = ST_IDLE;
                        c_d.st    = ST_SEND;
                    end
                end
            end
            ST_SEND: begin
                if (slot_free) begin
                    slot_load = 1'b1;
                    slot_byte = c_q.reply;
                    c_d.st    = c_q.ret;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '{st: ST_IDLE, ret: ST_IDLE, reply: 8'h00, addr_hi: 8'h00,
                     addr_lo: 8'h00, wbyte: 8'h00, fref: 8'h00};
        end else begin
            c_q <= c_d;
        end
    end

    assign bus_req_op = op_c;
    assign file_ref   = c_q.fref;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !tx_valid && !bus_req_valid && !file_open_req && rx_ready);

    // R10
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid && !bus_done |=> bus_req_valid && $stable(bus_req_op) && $stable(bus_req_wdata));

    // R10
    open_hold_chk: assert property (@(posedge clk) disable iff (rst)
        file_open_req && !file_open_done |=> file_open_req && $stable(file_ref));

    // R11
    rx_bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_ready && bus_req_valid));

    // R3
    page_align_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid && c_q.st == ST_W_AL |-> (bus_req_wdata & OFFS_MASK) == 8'h00);

endmodule

// File: tb/tb_eeprom_cmd_loader.sv
module tb_eeprom_cmd_loader;
    localparam int MEMB = 2048;
    localparam int PAGE = 8;
    localparam logic [7:0] SIZEB = 8'(MEMB / 256);
    localparam logic [7:0] AMASK = 8'(PAGE - 1);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_ready;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0;
    logic       bus_req_valid;
    logic [1:0] bus_req_op;
    logic [7:0] bus_req_wdata;
    logic       bus_done = 1'b0;
    logic       bus_nack = 1'b0;
    logic       file_open_req;
    logic [7:0] file_ref;
    logic       file_open_done = 1'b0;
    logic       file_open_ok = 1'b0;
    logic       file_data_valid = 1'b0;
    logic [7:0] file_data = 8'h00;
    logic       file_data_last = 1'b0;
    logic       file_data_ready;

    eeprom_cmd_loader #(.MEM_BYTES(MEMB), .PAGE_BYTES(PAGE), .DEV_WR(8'hA0)) dut (
        .clk(clk), .rst(rst),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .bus_req_valid(bus_req_valid), .bus_req_op(bus_req_op), .bus_req_wdata(bus_req_wdata),
        .bus_done(bus_done), .bus_nack(bus_nack),
        .file_open_req(file_open_req), .file_ref(file_ref),
        .file_open_done(file_open_done), .file_open_ok(file_open_ok),
        .file_data_valid(file_data_valid), .file_data(file_data),
        .file_data_last(file_data_last), .file_data_ready(file_data_ready)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int tx_mode = 0;

    logic [7:0] tx_log [0:127];
    int tx_n = 0;
    int bop [0:127];
    logic [7:0] bdat [0:127];
    int bop_n = 0;
    int wr_seen = 0;
    int nack_write = -1;
    int bcnt = 0;
    logic pend_nack = 1'b0;

    logic f_ok = 1'b1;
    int f_len = 1;
    logic [7:0] f_base = 8'h00;
    logic [7:0] got_ref = 8'h00;
    int opens = 0;
    int fo_cnt = 0;
    logic streaming = 1'b0;
    int sidx = 0;
    logic fs_acc = 1'b0;

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // transmit sink and watchdog
    always @(negedge clk) begin
        cyc++;
        if (tx_mode == 0)      tx_ready = 1'b1;
        else if (tx_mode == 1) tx_ready = cyc[0];
        else                   tx_ready = (cyc % 4 == 0);
        if (!rst && tx_valid && tx_ready && tx_n < 128) begin
            tx_log[tx_n] = tx_data;
            tx_n++;
        end
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: act cycles %0d exp < 150000", cyc);
            finish_run();
        end
    end

    // byte-level bus target model
    always @(negedge clk) begin
        if (rst) begin
            bus_done = 1'b0;
            bus_nack = 1'b0;
            bcnt = 0;
        end else if (bus_done) begin
            bus_done = 1'b0;
            bus_nack = 1'b0;
        end else if (bcnt > 0) begin
            bcnt--;
            if (bcnt == 0) begin
                bus_done = 1'b1;
                bus_nack = pend_nack;
            end
        end else if (bus_req_valid) begin
            if (bop_n < 128) begin
                bop[bop_n] = int'(bus_req_op);
                bdat[bop_n] = bus_req_wdata;
                bop_n++;
            end
            pend_nack = (bus_req_op == 2'd1) && (wr_seen == nack_write);
            if (bus_req_op == 2'd1) wr_seen++;
            bcnt = 2 + (bop_n % 2);
        end
    end

    // file reader model
    always @(negedge clk) begin
        if (rst) begin
            file_open_done = 1'b0;
            fo_cnt = 0;
            streaming = 1'b0;
            fs_acc = 1'b0;
            file_data_valid = 1'b0;
        end else begin
            if (file_open_done) begin
                file_open_done = 1'b0;
            end else if (fo_cnt > 0) begin
                fo_cnt--;
                if (fo_cnt == 0) begin
                    file_open_done = 1'b1;
                    file_open_ok = f_ok;
                    got_ref = file_ref;
                    if (f_ok) begin
                        streaming = 1'b1;
                        sidx = 0;
                    end
                end
            end else if (file_open_req) begin
                opens++;
                fo_cnt = 3;
            end
            if (fs_acc) begin
                sidx++;
                if (sidx == f_len) streaming = 1'b0;
            end
            file_data_valid = streaming;
            file_data = 8'(f_base + sidx * 5);
            file_data_last = (sidx == f_len - 1);
            fs_acc = file_data_valid && file_data_ready;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: act %0d exp %0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data = b;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic wait_tx(input int n);
        int t = 0;
        while (tx_n < n && t < 4000) begin
            @(negedge clk);
            t++;
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic clear_logs();
        tx_n = 0;
        bop_n = 0;
        wr_seen = 0;
        opens = 0;
    endtask

    task automatic do_probe(input string tag);
        clear_logs();
        send(8'h3F);
        wait_tx(2);
        chk(tag, tx_n, 2);
        chk(tag, int'(tx_log[0]), 8'h23);
        chk(tag, int'(tx_log[1]), int'(SIZEB));
        chk(tag, bop_n, 0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 tx_valid", int'(tx_valid), 0);
        chk("R1 bus_req_valid", int'(bus_req_valid), 0);
        chk("R1 file_open_req", int'(file_open_req), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rx_ready idle", int'(rx_ready), 1);

        // R2: probe under each back-pressure pattern
        for (int m = 0; m < 3; m++) begin
            tx_mode = m;
            do_probe("R2 probe");
        end

        // R9: unknown command bytes are ignored
        tx_mode = 0;
        for (int c = 0; c < 256; c += 17) begin
            clear_logs();
            send(8'(c));
            repeat (15) @(negedge clk);
            chk("R9 no reply", tx_n, 0);
            chk("R9 no bus", bop_n, 0);
            chk("R9 no open", opens, 0);
            chk("R9 idle", int'(rx_ready), 1);
        end
        do_probe("R9 idle after ignore");

        // R3 R5 R6 R11: page writes over a sweep of address bytes
        for (int k = 0; k < 6; k++) begin
            logic [7:0] ah;
            logic [7:0] al;
            ah = 8'(k * 37 + 1);
            al = 8'(k * 61 + 7);
            tx_mode = k % 3;
            nack_write = (k == 2) ? 5 : -1;
            clear_logs();
            send(8'h57);
            send(ah);
            send(al);
            for (int i = 0; i < PAGE; i++) send(8'(ah + 3 * i + k));
            wait_tx(2);
            chk("R5 reply count", tx_n, 2);
            chk("R5 open reply", int'(tx_log[0]), 8'h5B);
            chk("R6 close reply", int'(tx_log[1]), 8'h5D);
            chk("R3 op total", bop_n, 4 + PAGE + 1);
            chk("R3 start", bop[0], 0);
            chk("R3 dev op", bop[1], 1);
            chk("R3 dev byte", int'(bdat[1]), 8'hA0);
            chk("R3 addr hi", int'(bdat[2]), int'(ah));
            chk("R3 addr lo aligned", int'(bdat[3]), int'(al & ~AMASK));
            for (int i = 0; i < PAGE; i++) begin
                chk("R5 data op", bop[4 + i], 1);
                chk("R11 data byte", int'(bdat[4 + i]), int'(8'(ah + 3 * i + k)));
            end
            chk("R6 stop", bop[4 + PAGE], 3);
        end
        nack_write = -1;

        // R4: nack on each address-phase write
        for (int nk = 0; nk < 3; nk++) begin
            tx_mode = nk % 3;
            nack_write = nk;
            clear_logs();
            send(8'h57);
            send(8'h12);
            send(8'h34);
            wait_tx(1);
            chk("R4 reply count", tx_n, 1);
            chk("R4 error reply", int'(tx_log[0]), 8'h21);
            chk("R4 op total", bop_n, nk + 3);
            chk("R4 stop", bop[nk + 2], 3);
            chk("R4 idle", int'(rx_ready), 1);
        end
        nack_write = -1;
        do_probe("R4 idle after error");

        // R7: file reads of several lengths
        for (int len = 1; len < 6; len++) begin
            logic [7:0] rf;
            rf = 8'(len * 11);
            tx_mode = len % 3;
            f_ok = 1'b1;
            f_len = len;
            f_base = 8'(len * 40 + 3);
            clear_logs();
            send(8'h52);
            send(rf);
            wait_tx(len + 2);
            chk("R7 ref", int'(got_ref), int'(rf));
            chk("R7 reply count", tx_n, len + 2);
            chk("R7 open reply", int'(tx_log[0]), 8'h5B);
            for (int i = 0; i < len; i++)
                chk("R7 file byte", int'(tx_log[1 + i]), int'(8'(f_base + i * 5)));
            chk("R7 close reply", int'(tx_log[len + 1]), 8'h5D);
            chk("R7 no bus", bop_n, 0);
        end

        // R8: failed open
        for (int j = 0; j < 2; j++) begin
            tx_mode = j;
            f_ok = 1'b0;
            clear_logs();
            send(8'h52);
            send(8'(j * 90 + 5));
            wait_tx(1);
            chk("R8 ref", int'(got_ref), j * 90 + 5);
            chk("R8 reply count", tx_n, 1);
            chk("R8 error reply", int'(tx_log[0]), 8'h21);
        end
        f_ok = 1'b1;

        // R12: reset during a page write
        tx_mode = 0;
        clear_logs();
        send(8'h57);
        send(8'h01);
        send(8'h40);
        wait_tx(1);
        send(8'h99);
        send(8'h98);
        repeat (6) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R12 tx quiet in reset", int'(tx_valid), 0);
        chk("R12 bus quiet in reset", int'(bus_req_valid), 0);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk("R12 idle", int'(rx_ready), 1);
        do_probe("R12 probe after reset");

        finish_run();
    end
endmodule